// File: doc/BRIEF.md
# Eight-Channel Serial ADC Scan Controller

This block is the host side of a 16-clock serial link to an eight-input, 12-bit successive-approximation converter. It produces the active-low chip select, a serial clock derived from the system clock by a programmable divider, and the serial control stream toward the converter. It also shifts in the converter's serial data and hands each 12-bit result to the rest of the chip, together with a one-cycle valid pulse and the number of the channel that produced it.

In every 16-clock word, the converter takes the address of the channel it must convert next. It returns the result for the address it received in the word before. The controller therefore keeps the channel numbers it has sent in a one-word pipeline, so that each result carries the correct tag. It also drops the four zero bits that precede every result. A channel-enable mask picks the inputs to visit in ascending round-robin order.

Three scan modes are offered. Single mode runs one word and stops. Loop mode holds chip select low for back-to-back words until a stop request. Burst mode raises chip select for a programmable number of idle cycles between words, so the converter powers down in the gap.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, chip select and the serial clock are high, the serial data output is 0, and no result valid pulse is produced.
- R2: Each serial clock half-period lasts `cfg_div`+1 system clocks. Chip select falls while the serial clock is high, and it stays low for `cfg_div`+1 clocks before the first falling edge. Every chip-select-low window holds a whole number of 16-rising-edge words, and the serial clock toggles only while chip select is low.
- R3: The control byte of each word is sent MSB first. It is 2'b00, then the 3-bit channel number, then 3'b000, so the channel sits in bits 5:3. The controller changes its output bit on falling serial clock edges, so the converter reads it on rising edges 1 to 8. During rising edges 9 to 16 the output is 0.
- R4: The input is sampled on each rising edge. The first 4 bits of a word are discarded and the next 12 form the result, MSB first. `res_valid` pulses for exactly one system clock, starting one clock after the 16th rising edge, with `res_data` holding the result.
- R5: `res_chan` is the channel number sent in the previous word. The first word after reset is tagged channel 0.
- R6: Channels are sent in ascending order among the bits set in `cfg_chan_en`, wrapping from 7 to 0. After reset the first channel sent is the lowest enabled one. An all-zero mask sends channel 0.
- R7: In single mode (`cfg_mode`=0), `start` produces exactly one word, and chip select then returns high.
- R8: In loop mode (`cfg_mode`=1), chip select stays low across consecutive words. The first falling edge of the next word comes one half-period after the 16th rising edge. After `stop`, the current word completes and chip select rises.
- R9: In burst mode (`cfg_mode`=2), each window holds one word, and chip select stays high for `cfg_gap`+1 clocks between words until `stop`.
- R10: `res_err` is 1 with a result whenever any of the 4 discarded leading bits of its word was 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan when idle (one-clock pulse) |
| stop | input | 1 | End a loop or burst scan after the current word |
| cfg_mode | input | 2 | 0 single, 1 loop, 2 burst (3 acts as single) |
| cfg_div | input | DIV_W | Half-period of serial clock minus one, in system clocks |
| cfg_gap | input | GAP_W | Burst idle length minus one, in system clocks |
| cfg_chan_en | input | NCH | Channel-enable mask |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial control data to the converter |
| adc_miso | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | One-clock result strobe |
| res_chan | output | AW | Channel that produced the result |
| res_data | output | RES_W | 12-bit straight-binary result |
| res_err | output | 1 | Nonzero leading bits seen in this word |

## Verification
If the tag pipeline slips by one word, every result after the first shows a channel number off by one round-robin step, and this is visible at the first `res_valid` after the second word. A broken bit counter shows within one word: a window that does not end on a 16-edge boundary, or a result built from shifted data. A divider or gap counter that is off by one changes a measured interval between serial clock or chip select edges at the very first half-period or gap.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CTRL_BITS = 8;   // control byte length
  localparam int ADDR_POS  = 3;   // channel field lsb inside the control byte
  localparam int WORD_BITS = 16;  // serial clocks per conversion word
  localparam int RES_BITS  = 12;  // result width

  typedef enum logic [1:0] {
    SCAN_ONE   = 2'd0,
    SCAN_LOOP  = 2'd1,
    SCAN_BURST = 2'd2
  } scan_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_LAST,
    ST_GAP
  } scan_state_e;
endpackage

// File: rtl/adc_scan_clkdiv.sv
module adc_scan_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R2: half-period ticks never come back to back unless the divider is zero
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && en) |=> (!tick || div == '0));
endmodule

// File: rtl/adc_scan_chansel.sv
module adc_scan_chansel #(
  parameter int NCH = 8,
  parameter int AW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] mask,
  input  logic           advance,
  output logic [AW-1:0]  send_ch,
  output logic [AW-1:0]  conv_ch
);
  logic [AW-1:0] rr_q;
  logic [AW-1:0] sent_q;
  logic          hit;

  // round-robin search: first enabled channel after the last one sent
  always_comb begin
    send_ch = '0;
    hit     = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      if (!hit && mask[(int'(rr_q) + i) % NCH]) begin
        send_ch = AW'((int'(rr_q) + i) % NCH);
        hit     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q    <= AW'(NCH - 1);
      sent_q  <= '0;
      conv_ch <= '0;
    end else if (advance) begin
      conv_ch <= sent_q;
      sent_q  <= send_ch;
      rr_q    <= send_ch;
    end
  end

  // R6: a non-empty mask never yields a disabled channel
  p_pick_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && mask != '0) |-> mask[send_ch]);
  // R5: the converted channel only moves when a new word begins
  p_tag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(advance) |-> $stable(conv_ch));
endmodule

// File: rtl/adc_scan_shifter.sv
module adc_scan_shifter #(
  parameter int  CW  = 8,
  parameter int  WW  = 16,
  parameter int  RW  = 12,
  parameter bit  CHK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] word,
  input  logic          fall,
  input  logic          clr,
  input  logic          rise,
  input  logic          last,
  input  logic          miso,
  output logic          mosi,
  output logic          rx_valid,
  output logic [RW-1:0] rx_data,
  output logic          rx_err
);
  localparam int LW = WW - RW;

  logic [CW-1:0] tx_q;
  logic [CW-1:0] tx_src;
  logic [WW-1:0] rx_q;
  logic [WW-1:0] rx_nx;
  logic          lead_bad;

  assign tx_src = load ? word : tx_q;
  assign rx_nx  = {rx_q[WW-2:0], miso};

  generate
    if (CHK) begin : g_lead_chk
      assign lead_bad = |rx_nx[WW-1 -: LW];
    end else begin : g_lead_off
      assign lead_bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q     <= '0;
      mosi     <= 1'b0;
      rx_q     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (clr) begin
        mosi <= 1'b0;
        tx_q <= '0;
      end else if (fall) begin
        mosi <= tx_src[CW-1];
        tx_q <= {tx_src[CW-2:0], 1'b0};
      end else if (load) begin
        tx_q <= word;
      end
      if (rise) begin
        rx_q <= rx_nx;
        if (last) begin
          rx_data  <= rx_nx[RW-1:0];
          rx_err   <= lead_bad;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R4: results are single-cycle strobes
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DIV_W = 8,
  parameter int GAP_W = 16,
  parameter bit CHK   = 1'b1,
  parameter int AW    = $clog2(NCH),
  parameter int RES_W = RES_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [NCH-1:0]   cfg_chan_en,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso,
  output logic             res_valid,
  output logic [AW-1:0]    res_chan,
  output logic [RES_W-1:0] res_data,
  output logic             res_err
);
  localparam int EW = $clog2(WORD_BITS) + 1;

  scan_state_e      st;
  scan_mode_e       mode_q;
  logic             stop_q;
  logic [EW-1:0]    ecnt;
  logic [GAP_W-1:0] gcnt;
  logic             tick, clk_en;
  logic             advance, load, fall, rise, last, clr;
  logic             keep_low;
  logic [AW-1:0]    send_ch, conv_ch;
  logic [CTRL_BITS-1:0] ctrl_word;

  assign clk_en   = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_LAST);
  assign keep_low = (mode_q == SCAN_LOOP) && !stop_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[ADDR_POS +: AW] = send_ch;
  end

  always_comb begin
    advance = 1'b0;
    fall    = 1'b0;
    rise    = 1'b0;
    last    = 1'b0;
    clr     = 1'b0;
    unique case (st)
      ST_IDLE:  advance = start;
      ST_GAP:   advance = (gcnt == cfg_gap);
      ST_SETUP: fall = tick;
      ST_LOW: begin
        rise = tick;
        last = tick && (ecnt == EW'(WORD_BITS - 1));
      end
      ST_HIGH:  fall = tick;
      ST_LAST: begin
        advance = tick && keep_low;
        fall    = tick && keep_low;
        clr     = tick && !keep_low;
      end
      default: ;
    endcase
    load = advance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= SCAN_ONE;
      stop_q   <= 1'b0;
      ecnt     <= '0;
      gcnt     <= '0;
      adc_cs_n <= 1'b1;
      adc_sclk <= 1'b1;
      res_chan <= '0;
    end else begin
      if (stop && st != ST_IDLE) stop_q <= 1'b1;
      if (last) res_chan <= conv_ch;
      unique case (st)
        ST_IDLE: begin
          adc_cs_n <= 1'b1;
          adc_sclk <= 1'b1;
          if (start) begin
            mode_q   <= (cfg_mode == 2'd3) ? SCAN_ONE : scan_mode_e'(cfg_mode);
            stop_q   <= 1'b0;
            adc_cs_n <= 1'b0;
            st       <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) begin
          adc_sclk <= 1'b0;
          ecnt     <= '0;
          st       <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          adc_sclk <= 1'b1;
          ecnt     <= ecnt + 1'b1;
          st       <= last ? ST_LAST : ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          adc_sclk <= 1'b0;
          st       <= ST_LOW;
        end
        ST_LAST: if (tick) begin
          if (keep_low) begin
            adc_sclk <= 1'b0;
            ecnt     <= '0;
            st       <= ST_LOW;
          end else begin
            adc_cs_n <= 1'b1;
            gcnt     <= '0;
            st       <= (mode_q == SCAN_BURST && !stop_q) ? ST_GAP : ST_IDLE;
          end
        end
        ST_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == cfg_gap) begin
            adc_cs_n <= 1'b0;
            st       <= ST_SETUP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  adc_scan_clkdiv #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(clk_en), .div(cfg_div), .tick(tick)
  );

  adc_scan_chansel #(.NCH(NCH), .AW(AW)) u_chan (
    .clk(clk), .rst(rst), .mask(cfg_chan_en), .advance(advance),
    .send_ch(send_ch), .conv_ch(conv_ch)
  );

  adc_scan_shifter #(.CW(CTRL_BITS), .WW(WORD_BITS), .RW(RES_W), .CHK(CHK)) u_shift (
    .clk(clk), .rst(rst), .load(load), .word(ctrl_word), .fall(fall), .clr(clr),
    .rise(rise), .last(last), .miso(adc_miso), .mosi(adc_mosi),
    .rx_valid(res_valid), .rx_data(res_data), .rx_err(res_err)
  );

  // R1: with chip select high the bus sits in its idle levels
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> (adc_sclk && !adc_mosi));
  // R2: serial clock moves only inside a chip-select window
  p_sclk_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_sclk) |-> !adc_cs_n);
  // R2: chip select falls with the serial clock high
  p_cs_fall_high_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> adc_sclk);
  // R3: padding bits after the control byte are zero
  p_mosi_pad_r3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LOW || st == ST_HIGH) && ecnt >= EW'(CTRL_BITS)) |-> !adc_mosi);
  // R7: a single scan releases chip select after its word
  p_single_once_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LAST && tick && mode_q == SCAN_ONE) |=> adc_cs_n);
  // R9: the burst gap keeps chip select high
  p_gap_high_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> adc_cs_n);
endmodule

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, stop = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [7:0]  cfg_div = 8'd0;
  logic [15:0] cfg_gap = 16'd0;
  logic [7:0]  cfg_chan_en = 8'hFF;
  logic adc_cs_n, adc_sclk, adc_mosi;
  logic adc_miso = 1'b0;
  logic res_valid, res_err;
  logic [2:0]  res_chan;
  logic [11:0] res_data;

  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;

  adc_scan_ctrl i_adc_scan_ctrl (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .cfg_mode(cfg_mode),
    .cfg_div(cfg_div), .cfg_gap(cfg_gap), .cfg_chan_en(cfg_chan_en),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data), .res_err(res_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] next_ch(input logic [2:0] r, input logic [7:0] m);
    if (m == 8'h00) return 3'd0;
    for (int i = 1; i <= 8; i++)
      if (m[(r + i) % 8]) return 3'((r + i) % 8);
    return 3'd0;
  endfunction

  // converter model and monitors, evaluated away from the active edge
  logic        p_cs = 1'b1, p_sc = 1'b1;
  int          rises = 0, falls = 0, words = 0, last_evt = 0, cs_rise_at = 0;
  logic [7:0]  ctl = '0;
  logic [2:0]  conv = '0, new_addr = '0, rr_exp = 3'd7;
  logic [15:0] mword = '0;
  logic [3:0]  lead = 4'h0;
  logic [2:0]  e_ch  [0:255];
  logic [11:0] e_dat [0:255];
  logic        e_err [0:255];
  int          wr = 0, rd = 0;
  bit          first_res = 1, in_burst = 0, have_rise = 0, loop_run = 0;

  always @(negedge clk) begin
    if (rst) begin
      p_cs = 1; p_sc = 1; rises = 0; falls = 0; conv = '0; rr_exp = 3'd7;
      wr = 0; rd = 0; first_res = 1; have_rise = 0; adc_miso = 0;
    end else begin
      if (p_cs && !adc_cs_n) begin
        words = 0; rises = 0; falls = 0; last_evt = cyc;
        if (in_burst && have_rise)
          check(cyc - cs_rise_at == int'(cfg_gap) + 1, "R9 gap length", cyc - cs_rise_at, int'(cfg_gap) + 1);
      end else if (!p_cs && !adc_cs_n && adc_sclk != p_sc) begin
        check(cyc - last_evt == int'(cfg_div) + 1, "R2 half period", cyc - last_evt, int'(cfg_div) + 1);
        last_evt = cyc;
        if (!adc_sclk) begin
          if (falls == 0) begin
            mword = {lead, 12'($urandom)};
          end
          adc_miso = mword[15 - falls];
          falls++;
        end else begin
          if (rises < 8) ctl = {ctl[6:0], adc_mosi};
          else check(adc_mosi == 1'b0, "R3 pad bit", adc_mosi, 0);
          rises++;
          if (rises == 8) begin
            new_addr = next_ch(rr_exp, cfg_chan_en);
            check(ctl[5:3] == new_addr, "R6 channel order", ctl[5:3], new_addr);
            check({ctl[7:6], ctl[2:0]} == 5'd0, "R3 control zeros", ctl, 0);
            rr_exp = new_addr;
          end
          if (rises == 16) begin
            e_ch[wr[7:0]] = conv; e_dat[wr[7:0]] = mword[11:0]; e_err[wr[7:0]] = (mword[15:12] != 0);
            wr++;
            conv = new_addr; rises = 0; falls = 0; words++;
          end
        end
      end else if (!p_cs && adc_cs_n) begin
        check(rises == 0, "R2 whole words", rises, 0);
        if (loop_run) check(words >= 2, "R8 back-to-back words", words, 2);
        else check(words == 1, "R7/R9 one word per window", words, 1);
        cs_rise_at = cyc; have_rise = 1; adc_miso = 0;
      end
      if (res_valid) begin
        if (rd >= wr) check(0, "R4 unexpected valid", rd, wr);
        else begin
          check(res_chan == e_ch[rd[7:0]], "R5 result tag", res_chan, e_ch[rd[7:0]]);
          check(res_data == e_dat[rd[7:0]], "R4 result data", res_data, e_dat[rd[7:0]]);
          check(res_err == e_err[rd[7:0]], "R10 lead flag", res_err, e_err[rd[7:0]]);
          if (first_res) check(res_chan == 3'd0, "R5 first tag", res_chan, 0);
          first_res = 0;
          rd++;
        end
      end
      p_cs = adc_cs_n; p_sc = adc_sclk;
    end
  end

  task automatic pulse_start();
    @(posedge clk) #1 start = 1'b1;
    @(posedge clk) #1 start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(posedge clk) #1 stop = 1'b1;
    @(posedge clk) #1 stop = 1'b0;
  endtask

  task automatic wait_results(input int n);
    int target = rd + n;
    while (rd < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    int hi = 0;
    while (hi <= int'(cfg_gap) + 4) begin
      @(negedge clk);
      hi = adc_cs_n ? hi + 1 : 0;
    end
    check(rd == wr, "R4 all results delivered", rd, wr);
  endtask

  task automatic run_single(input logic [7:0] div, input logic [7:0] mask);
    cfg_mode = 2'd0; cfg_div = div; cfg_chan_en = mask;
    pulse_start();
    wait_results(1);
    wait_idle();
  endtask

  task automatic run_stream(input logic [1:0] mode, input int n);
    loop_run = (mode == 2'd1); in_burst = (mode == 2'd2); have_rise = 0;
    cfg_mode = mode;
    pulse_start();
    wait_results(n);
    pulse_stop();
    wait_idle();
    loop_run = 0; in_burst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset levels
    check(adc_cs_n == 1'b1, "R1 cs idle", adc_cs_n, 1);
    check(adc_sclk == 1'b1, "R1 sclk idle", adc_sclk, 1);
    check(adc_mosi == 1'b0, "R1 mosi idle", adc_mosi, 0);
    check(res_valid == 1'b0, "R1 no valid", res_valid, 0);

    // R7, R5: single words, first tag is channel 0
    run_single(8'd0, 8'hFF);
    run_single(8'd0, 8'hFF);
    run_single(8'd3, 8'b1010_0100);
    run_single(8'd1, 8'h00);     // R6 empty mask
    run_single(8'd1, 8'h00);

    // R10: nonzero leading bits are flagged, then cleared
    lead = 4'b0100;
    run_single(8'd0, 8'h81);
    lead = 4'b0000;
    run_single(8'd0, 8'h81);

    // R8: loop mode, directed then random settings
    cfg_div = 8'd0; cfg_chan_en = 8'b0000_0001;
    run_stream(2'd1, 6);
    for (int k = 0; k < 3; k++) begin
      cfg_div = 8'($urandom_range(0, 5));
      cfg_chan_en = 8'($urandom_range(1, 255));
      run_stream(2'd1, 12);
    end

    // R9: burst mode with zero and random gaps
    cfg_div = 8'd0; cfg_gap = 16'd0; cfg_chan_en = 8'hF0;
    run_stream(2'd2, 5);
    for (int k = 0; k < 3; k++) begin
      cfg_div = 8'($urandom_range(0, 4));
      cfg_gap = 16'($urandom_range(1, 40));
      cfg_chan_en = 8'($urandom_range(0, 255));
      run_stream(2'd2, 8);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule